// File: doc/BRIEF.md
# Recursive Crosswise Unsigned Multiplier

This block multiplies two unsigned operands of `W` bits (64 by default) and returns the full product of `2*W` bits. The product is formed by recursive four-quadrant splitting. Each node of width N splits both operands into upper and lower halves and multiplies the four half pairs in child nodes of width N/2. It then adds the two cross terms, and adds that sum, shifted by N/2, to the concatenation of the high-high and low-low products. Each column of the result therefore collects every cross product whose index pair sums to that column. The recursion ends at a 2×2 cell whose four output bits are written directly as crosswise equations. Every addition inside a node uses a Kogge-Stone parallel-prefix adder. Each of these adders is sized so that no carry is ever dropped.

Operands enter through a valid/ready handshake and the product leaves through another one. When `REG_OUT` is 1 (the default), a single output register sits after the combinational core. A pair is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its product is presented with `out_valid` from the next cycle on. The product holds until a rising edge where `out_ready` is high. The stage takes a new pair in the same cycle that it hands one out, so it sustains one product per cycle. When `REG_OUT` is 0 the core is combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. Typical use is as the multiply stage in front of an accumulator that adds each new product to its running total.

Top module: `rmul_top`

## Requirements
- R1: For any pair of operands, `out_prod` equals the unsigned product `in_a * in_b`, computed at the full `2*W` bits.
- R2: No intermediate sum is truncated. With both operands all ones, the product is 2^128 − 2^65 + 1, and the top bit and all upper bits are correct.
- R3: With `REG_OUT`=1, a pair accepted on a rising edge has its product on `out_prod`, with `out_valid` high, right after that same edge.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_prod` do not change across the clock edge.
- R5: `in_ready` is high whenever `out_valid` is low. While `out_valid` is high, `in_ready` follows `out_ready`.
- R6: While `rst_n` is low, and right after it is released, `out_valid` is low and `in_ready` is high.
- R7: With `out_ready` held high, a new pair is accepted on every cycle, and products leave in the order their operands were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | W | Multiplicand, unsigned |
| in_b | input | W | Multiplier, unsigned |
| out_valid | output | 1 | Product is present |
| out_ready | input | 1 | Consumer takes the product |
| out_prod | output | 2*W | Unsigned product |

## Verification
The bench targets the operand patterns that expose errors in carry handling. All-ones operands drive every cross-term and outer carry to its limit, so an adder one bit too narrow or a lost prefix carry would corrupt the top bits. Single set bits at the half boundaries (bits 31, 32 and 63) land in exactly one quadrant, so a swapped or mis-shifted quadrant would move the bit to the wrong column. Alternating patterns and random pairs exercise mixed carry chains. Random back-pressure on `out_ready` checks that a stalled product is neither overwritten nor dropped.

// File: rtl/rmul_pkg.sv
package rmul_pkg;
  // Product width for a given operand width.
  function automatic int prod_w(input int w);
    return 2 * w;
  endfunction

  // Operand width must be a power of two, at least 2, for the quadrant split.
  function automatic bit width_ok(input int w);
    return (w >= 2) && ((w & (w - 1)) == 0);
  endfunction
endpackage

// File: rtl/ks_add.sv
// Kogge-Stone prefix adder, carry-in tied to zero, carry-out dropped
// (callers size W so the sum always fits).
module ks_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  localparam int S = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] g [0:S];
  logic [W-1:0] p [0:S];

  assign g[0] = a & b;
  assign p[0] = a ^ b;

  for (genvar k = 0; k < S; k++) begin : g_stage
    localparam int D = 1 << k;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_merge
        assign g[k+1][i] = g[k][i] | (p[k][i] & g[k][i-D]);
        assign p[k+1][i] = p[k][i] & p[k][i-D];
      end else begin : g_pass
        assign g[k+1][i] = g[k][i];
        assign p[k+1][i] = p[k][i];
      end
    end
  end

  assign sum[0] = p[0][0];
  for (genvar i = 1; i < W; i++) begin : g_sum
    assign sum[i] = p[0][i] ^ g[S][i-1];
  end
endmodule

// File: rtl/xw_cell2.sv
// 2x2 crosswise cell: vertical, crosswise, then carries.
module xw_cell2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic cross_lo, cross_hi, top, c1;
  assign cross_lo = a[1] & b[0];
  assign cross_hi = a[0] & b[1];
  assign top      = a[1] & b[1];
  assign c1       = cross_lo & cross_hi;
  assign p[0] = a[0] & b[0];
  assign p[1] = cross_lo ^ cross_hi;
  assign p[2] = top ^ c1;
  assign p[3] = top & c1;
endmodule

// File: rtl/xw_node.sv
// Recursive N x N node built from four N/2 x N/2 nodes.
module xw_node #(
  parameter int N = 64
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  localparam int H = N / 2;

  if (N == 2) begin : g_leaf
    xw_cell2 u_cell (.a(a), .b(b), .p(p));
  end else begin : g_split
    logic [N-1:0] hh, hl, lh, ll;
    logic [N:0]   mid;
    logic [2*N-1:0] mid_sh;

    xw_node #(.N(H)) u_hh (.a(a[N-1:H]), .b(b[N-1:H]), .p(hh));
    xw_node #(.N(H)) u_hl (.a(a[N-1:H]), .b(b[H-1:0]), .p(hl));
    xw_node #(.N(H)) u_lh (.a(a[H-1:0]), .b(b[N-1:H]), .p(lh));
    xw_node #(.N(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(ll));

    // Cross terms summed one bit wider than either, before shifting.
    ks_add #(.W(N+1)) u_mid (.a({1'b0, hl}), .b({1'b0, lh}), .sum(mid));

    assign mid_sh = {{(N-1-H){1'b0}}, mid, {H{1'b0}}};

    // hh<<N and ll do not overlap, so they concatenate.
    ks_add #(.W(2*N)) u_out (.a({hh, ll}), .b(mid_sh), .sum(p));
  end
endmodule

// File: rtl/rmul_top.sv
module rmul_top #(
  parameter int W       = 64,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [W-1:0]                     in_a,
  input  logic [W-1:0]                     in_b,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [rmul_pkg::prod_w(W)-1:0]   out_prod
);
  localparam int PW = rmul_pkg::prod_w(W);

  logic [PW-1:0] core_prod;

  xw_node #(.N(W)) u_core (.a(in_a), .b(in_b), .p(core_prod));

  if (REG_OUT) begin : g_reg
    logic          vld_q;
    logic [PW-1:0] prod_q;
    logic          take;

    assign in_ready = !vld_q || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        prod_q <= '0;
      end else begin
        if (take) begin
          vld_q  <= 1'b1;
          prod_q <= core_prod;
        end else if (out_ready) begin
          vld_q  <= 1'b0;
        end
      end
    end

    assign out_valid = vld_q;
    assign out_prod  = prod_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_prod  = core_prod;
  end
endmodule

// File: rtl/rmul_chk.sv
module rmul_chk #(
  parameter int W       = 64,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [W-1:0]   in_a,
  input logic [W-1:0]   in_b,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*W-1:0] out_prod,
  input logic [2*W-1:0] core_prod
);
  logic [2*W-1:0] ref_prod;
  assign ref_prod = {{W{1'b0}}, in_a} * {{W{1'b0}}, in_b};

  initial begin
    assert (rmul_pkg::width_ok(W)) else $error("operand width must be a power of two");
  end

  // R1 / R2: recursive core agrees with a full-width reference product.
  p_core_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> core_prod == ref_prod);

  if (REG_OUT) begin : g_reg_chk
    // R3: accepted pair is presented on the next cycle.
    p_accept_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_valid && out_prod == $past(ref_prod)));

    // R4: stalled product holds.
    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_prod)));

    // R5: empty stage always takes input.
    p_empty_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

    // R6: nothing valid while in reset.
    p_reset_idle_r6: assert property (@(posedge clk)
      !rst_n |-> !out_valid);
  end
endmodule

bind rmul_top rmul_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_prod(out_prod), .core_prod(core_prod)
);

// File: tb/sim_rmul_top.sv
`timescale 1ns/1ps
module sim_rmul_top;
  localparam int W  = 64;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_a = '0;
  logic [W-1:0]  in_b = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [PW-1:0] out_prod;

  int checks = 0;
  int errors = 0;
  bit random_ready = 1'b0;
  bit monitor_on = 1'b0;
  int stalls = 0;
  logic [PW-1:0] exp_q [$];

  always #2.5 clk = ~clk;

  rmul_top #(.W(W), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_prod(out_prod)
  );

  task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: presents one pair, waits for acceptance, pushes the expectation.
  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b;
    #2;
    while (!in_ready) begin
      stalls++;
      @(negedge clk);
      #2;
    end
    exp_q.push_back({{W{1'b0}}, a} * {{W{1'b0}}, b});
    @(posedge clk);
    #0.1;
    in_valid = 1'b0;
  endtask

  // Monitor: sets out_ready, then compares any product leaving this cycle.
  logic [PW-1:0] last_prod;
  bit last_stall = 1'b0;
  always @(negedge clk) begin
    if (monitor_on) begin
      out_ready = random_ready ? ($urandom_range(0, 2) != 0) : 1'b1;
      #1;
      if (last_stall) begin
        // R4: stalled output holds across the edge
        check(out_valid && out_prod == last_prod, "R4", out_prod, last_prod);
      end
      // R5: ready follows consumer while full, high while empty
      check(in_ready == (!out_valid || out_ready), "R5", {127'b0, in_ready},
            {127'b0, (!out_valid || out_ready)});
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 (unexpected product)", out_prod, '0);
        end else begin
          logic [PW-1:0] e;
          e = exp_q.pop_front();
          // R1: exact full-width product, in order (R7)
          check(out_prod == e, "R1/R7", out_prod, e);
        end
      end
      last_stall = out_valid && !out_ready;
      last_prod  = out_prod;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [PW-1:0] e;
    // R6: reset state
    #1;
    check(!out_valid, "R6", {127'b0, out_valid}, '0);
    check(in_ready, "R6", {127'b0, in_ready}, {127'b0, 1'b1});
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R6", {126'b0, out_valid, in_ready}, 128'd1);

    // R3: directed latency check with consumer ready
    in_valid = 1'b1; in_a = 64'd7; in_b = 64'd9;
    @(posedge clk);
    #0.1;
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid && out_prod == 128'd63, "R3", out_prod, 128'd63);
    @(posedge clk);

    monitor_on = 1'b1;

    // R2: all ones
    drive('1, '1);
    e = {{W{1'b0}}, {W{1'b1}}} * {{W{1'b0}}, {W{1'b1}}};
    // explicit value check of the known constant
    check(e == {64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_0000_0000_0001}, "R2", e,
          {64'hFFFF_FFFF_FFFF_FFFE, 64'h1});
    drive('0, '1);
    drive('1, 64'd1);
    drive(64'd1 << 63, 64'd1 << 63);
    drive(64'd1 << 31, 64'd1 << 32);
    drive(64'd1 << 32, 64'd1 << 31);
    drive(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555);
    drive(64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA);
    drive(64'hFFFF_FFFF_0000_0000, 64'h0000_0000_FFFF_FFFF);
    for (int i = 0; i < 64; i++) drive(64'd1 << i, '1);

    // R7: full throughput with consumer always ready
    stalls = 0;
    for (int i = 0; i < 32; i++) drive({$urandom, $urandom}, {$urandom, $urandom});
    check(stalls == 0, "R7", stalls, '0);

    // R4: random back-pressure with random operands
    random_ready = 1'b1;
    for (int i = 0; i < 200; i++) drive({$urandom, $urandom}, {$urandom, $urandom});
    random_ready = 1'b0;

    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(posedge clk);
    check(exp_q.size() == 0, "R7 (drained)", exp_q.size(), '0);
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule